// File: doc/BRIEF.md
# ChaCha Double-Round Permutation Core

This block applies the 20-round ChaCha permutation to a 512-bit state made of sixteen 32-bit words. A start pulse copies the whole input state into an internal register file. The core then walks a fixed operand schedule, one add-xor-rotate step per clock. Each step adds one word into another, XORs the sum into a third word, and rotates that third word left. After 320 steps, done pulses for one cycle and the permuted state is available on the output.

There is one shared arithmetic unit, not four parallel quarter-round units. The word indices for each step come from a small computed schedule indexed by a step counter. A double round is split into a column half and a diagonal half. A round counter repeats the double round ten times. The block is meant to sit inside a stream-cipher datapath. That surrounding logic handles key and nonce setup, the final feed-forward addition and the keystream XOR.

Top module: `chacha_perm_core`

## Requirements
- R1: Word k of the state (k = 0..15) occupies bits [32k+31:32k] of both state_i and state_o. Word 0 is in the least significant bits. As a 4x4 array the words are in row-major order: word k sits in row k/4, column k%4.
- R2: A start pulse while the core is idle loads state_i in parallel. busy_o is high from the next cycle.
- R3: busy_o stays high for exactly 320 cycles, one step per cycle. In the cycle after the last step, done_o is high for exactly one cycle and busy_o is low.
- R4: Each quarter round on words (a,b,c,d) runs four steps in this order:
  - a+=b, then d=(d^a)<<<16
  - c+=d, then b=(b^c)<<<12
  - a+=b, then d=(d^a)<<<8
  - c+=d, then b=(b^c)<<<7

  Each step sees the results of the step before it.
- R5: A double round does the column groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15) first. It then does the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). Ten double rounds make up one run.
- R6: All additions wrap modulo 2^32, and all rotations are 32-bit circular left rotations.
- R7: A start pulse while busy_o is high is ignored. Neither the running computation nor its result is affected.
- R8: While idle with no start, state_o holds its value. done_o does not pulse again until a new run ends.
- R9: After a synchronous reset, busy_o and done_o are low and state_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads state_i when idle |
| state_i | input | 512 | Input state, word k at bits [32k+31:32k] |
| busy_o | output | 1 | High while the permutation is running |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| state_o | output | 512 | Current (and, when done, final) state |

## Verification
The all-zero state is used first; it must come back unchanged, so a wrong idle or load path shows up clearly. A state with only word 0 set exposes any error in word ordering or operand schedule, because the value spreads into other words according to the column/diagonal pattern. An all-ones state forces carries out of bit 31 on the first additions, which checks the modulo-2^32 wrap. An ascending-index state and several seeded random states are compared against a behavioural reference permutation in the bench. Rotate order, step order and group order are each caught there by a result mismatch. A second start issued mid-run with different data must leave the result equal to the model of the first state.

// File: rtl/chacha_core_pkg.sv
package chacha_core_pkg;

    localparam int WORD_W       = 32;
    localparam int NUM_WORDS    = 16;
    localparam int IDX_W        = $clog2(NUM_WORDS);
    localparam int STATE_W      = WORD_W * NUM_WORDS;
    localparam int STEPS_PER_DR = 32;
    localparam int STEP_W       = $clog2(STEPS_PER_DR);
    localparam int ROT_W        = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [ROT_W-1:0]  rot_t;

    // One add-xor-rotate step: sum_dst += sum_src; mix_dst = (mix_dst ^ sum) <<< rot
    typedef struct packed {
        widx_t sum_dst;
        widx_t sum_src;
        widx_t mix_dst;
        rot_t  rot;
    } step_op_t;

    // Step s of a double round: group s[4:2] (0..3 column, 4..7 diagonal), phase s[1:0]
    function automatic step_op_t step_op(input step_t s);
        step_op_t op;
        logic [2:0] grp;
        logic [1:0] lane;
        widx_t a, b, c, d;
        grp  = s[4:2];
        lane = grp[1:0];
        a    = {2'b00, lane};
        if (!grp[2]) begin
            b = {2'b01, lane};
            c = {2'b10, lane};
            d = {2'b11, lane};
        end else begin
            b = {2'b01, lane + 2'd1};
            c = {2'b10, lane + 2'd2};
            d = {2'b11, lane + 2'd3};
        end
        case (s[1:0])
            2'd0:    op = '{sum_dst: a, sum_src: b, mix_dst: d, rot: rot_t'(16)};
            2'd1:    op = '{sum_dst: c, sum_src: d, mix_dst: b, rot: rot_t'(12)};
            2'd2:    op = '{sum_dst: a, sum_src: b, mix_dst: d, rot: rot_t'(8)};
            default: op = '{sum_dst: c, sum_src: d, mix_dst: b, rot: rot_t'(7)};
        endcase
        return op;
    endfunction

    function automatic word_t rotl(input word_t x, input rot_t n);
        return (x << n) | (x >> (WORD_W - int'(n)));
    endfunction

endpackage

// File: rtl/chacha_sched.sv
module chacha_sched
    import chacha_core_pkg::*;
(
    input  step_t    step_i,
    output step_op_t op_o
);
    always_comb op_o = step_op(step_i);
endmodule

// File: rtl/chacha_alu.sv
module chacha_alu
    import chacha_core_pkg::*;
(
    input  word_t sum_dst_i,
    input  word_t sum_src_i,
    input  word_t mix_i,
    input  rot_t  rot_i,
    output word_t sum_o,
    output word_t mix_o
);
    word_t sum_w;
    always_comb begin
        sum_w = sum_dst_i + sum_src_i;   // wraps modulo 2^32 (R6)
        sum_o = sum_w;
        mix_o = rotl(mix_i ^ sum_w, rot_i);
    end
endmodule

// File: rtl/chacha_seq.sv
module chacha_seq
    import chacha_core_pkg::*;
#(
    parameter int NUM_DR = 10
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  start_i,
    output logic  busy_o,
    output logic  done_o,
    output logic  load_o,
    output step_t step_o
);
    localparam int DR_W = $clog2(NUM_DR + 1);

    logic            busy_q, done_q;
    step_t           step_q;
    logic [DR_W-1:0] dr_q;
    logic            last_w;

    assign load_o = start_i && !busy_q;
    assign last_w = busy_q && (step_q == step_t'(STEPS_PER_DR - 1))
                    && (dr_q == DR_W'(NUM_DR - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= '0;
            dr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                step_q <= '0;
                dr_q   <= '0;
            end else if (busy_q) begin
                step_q <= step_q + step_t'(1);
                if (step_q == step_t'(STEPS_PER_DR - 1))
                    dr_q <= dr_q + DR_W'(1);
                if (last_w) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign step_o = step_q;

    assert_done_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> !done_q);
    assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |-> !busy_q);
    assert_ignore_start_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && start_i && !last_w) |=> (busy_q && step_q == $past(step_q) + step_t'(1)));
endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
    import chacha_core_pkg::*;
#(
    parameter int NUM_DR = 10
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  start_i,
    input  logic [STATE_W-1:0]    state_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [STATE_W-1:0]    state_o
);
    word_t    state_q [NUM_WORDS];
    logic     busy_w, load_w;
    step_t    step_w;
    step_op_t op_w;
    word_t    sum_w, mix_w;

    chacha_seq #(.NUM_DR(NUM_DR)) seq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .busy_o  (busy_w),
        .done_o  (done_o),
        .load_o  (load_w),
        .step_o  (step_w)
    );

    chacha_sched sched_i (
        .step_i (step_w),
        .op_o   (op_w)
    );

    chacha_alu alu_i (
        .sum_dst_i (state_q[op_w.sum_dst]),
        .sum_src_i (state_q[op_w.sum_src]),
        .mix_i     (state_q[op_w.mix_dst]),
        .rot_i     (op_w.rot),
        .sum_o     (sum_w),
        .mix_o     (mix_w)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < NUM_WORDS; k++) state_q[k] <= '0;
        end else if (load_w) begin
            for (int k = 0; k < NUM_WORDS; k++) state_q[k] <= state_i[k*WORD_W +: WORD_W];
        end else if (busy_w) begin
            state_q[op_w.sum_dst] <= sum_w;
            state_q[op_w.mix_dst] <= mix_w;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pack
        assign state_o[g*WORD_W +: WORD_W] = state_q[g];
    end

    assign busy_o = busy_w;

    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_w && !start_i) |=> $stable(state_o));
    assert_distinct_words_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_w |-> (op_w.sum_dst != op_w.mix_dst && op_w.sum_dst != op_w.sum_src
                    && op_w.sum_src != op_w.mix_dst));
    assert_load_busy_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_w) |=> busy_w);
endmodule

// File: tb/chacha_perm_core_tb.sv
module chacha_perm_core_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [511:0] st_in;
    logic         busy, done;
    logic [511:0] st_out;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    chacha_perm_core dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .state_i(st_in),
        .busy_o(busy), .done_o(done), .state_o(st_out)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] qr(input logic [31:0] a, b, c, d);
        a = a + b; d = rl(d ^ a, 16);
        c = c + d; b = rl(b ^ c, 12);
        a = a + b; d = rl(d ^ a, 8);
        c = c + d; b = rl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] model(input logic [511:0] s);
        logic [31:0] x [16];
        logic [127:0] r;
        logic [511:0] o;
        for (int i = 0; i < 16; i++) x[i] = s[32*i +: 32];
        for (int dr = 0; dr < 10; dr++) begin
            for (int c = 0; c < 4; c++) begin
                r = qr(x[c], x[c+4], x[c+8], x[c+12]);
                {x[c], x[c+4], x[c+8], x[c+12]} = r;
            end
            for (int c = 0; c < 4; c++) begin
                r = qr(x[c], x[4+(c+1)%4], x[8+(c+2)%4], x[12+(c+3)%4]);
                {x[c], x[4+(c+1)%4], x[8+(c+2)%4], x[12+(c+3)%4]} = r;
            end
        end
        for (int i = 0; i < 16; i++) o[32*i +: 32] = x[i];
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one permutation; optionally pulses a second start mid-run with other data.
    task automatic run(input logic [511:0] s, input string req, input bit disturb);
        int cnt;
        logic [511:0] exp;
        exp = model(s);
        @(negedge clk);
        start = 1'b1; st_in = s;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", {511'd0, busy}, 512'd1);
        cnt = 0;
        while (busy === 1'b1 && cnt < 1000) begin
            cnt++;
            if (disturb && cnt == 100) begin
                start = 1'b1; st_in = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(cnt == 320, "R3", 512'(cnt), 512'd320);
        check(done === 1'b1, "R3", {511'd0, done}, 512'd1);
        check(st_out === exp, disturb ? "R7" : req, st_out, exp);
        @(negedge clk);
        check(done === 1'b0, "R3", {511'd0, done}, 512'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [511:0] s, held;
        void'($urandom(32'd2024));
        rst = 1'b1; start = 1'b0; st_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy === 1'b0 && done === 1'b0, "R9", {510'd0, busy, done}, 512'd0);
        check(st_out === '0, "R9", st_out, 512'd0);

        run('0, "R4", 1'b0);                       // zero state is a fixed point
        run(512'd1, "R1", 1'b0);                   // only word 0 set: layout/schedule
        run({512{1'b1}}, "R6", 1'b0);              // carries out of bit 31
        for (int i = 0; i < 16; i++) s[32*i +: 32] = 32'(i);
        run(s, "R5", 1'b0);                        // ascending words
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 16; i++) s[32*i +: 32] = $urandom;
            run(s, "R4", 1'b0);
        end
        // R7 mid-run start with different data is ignored
        for (int i = 0; i < 16; i++) s[32*i +: 32] = $urandom;
        run(s, "R7", 1'b1);

        // R8 output held while idle, no stray done
        held = st_out;
        st_in = ~held;
        repeat (20) @(negedge clk);
        check(st_out === held, "R8", st_out, held);
        check(done === 1'b0 && busy === 1'b0, "R8", {510'd0, busy, done}, 512'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule